// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Pair

The block counts active edges on two input pins with two 8-bit accumulators, a low one fed from pin 0 and a high one fed from pin 1. Each pin passes through a two-flop synchroniser and an edge detector. A control bit selects which edge is active, rising or falling. When the cascade bit is set, the two accumulators form one 16-bit counter. That counter is fed only from pin 0, and the carry out of the low byte increments the high byte. When the cascade bit is clear, each accumulator counts its own pin. It does so only while its own enable bit and the timer-enable input are both high.

A carry out of the high byte raises an overflow flag. The flag drives the interrupt output when the interrupt enable is set. In max-count mode the high byte stops at 0xFF instead of wrapping, and an active edge that arrives while it is pinned there still raises the flag. The flag clears in one of two ways. Normally a write of one to the flag register clears it. In fast-clear mode that write is ignored, and any read or write of a count register clears the flag instead.

Software reaches the block through a 2-bit address, a write strobe, a read strobe and combinational read data.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset, all four registers read 0 and irq_o is low.
- R2: Control bit 6 selects the active edge: 0 counts rising edges, 1 counts falling edges. Each active edge on a pin adds exactly one to its count, and the new count is readable within four clock cycles.
- R3: With control bit 0 clear, the low count (address 3) counts pin 0 only while control bit 2 and timer_en_i are both high. The high count (address 2) counts pin 1 only while control bit 3 and timer_en_i are both high. A wrap of the low count from 0xFF to 0x00 leaves the flag clear.
- R4: With control bit 0 set, address 2 holds the upper byte and address 3 the lower byte of one 16-bit count fed from pin 0. Control bits 2 and 3, pin 1 and timer_en_i have no effect on it.
- R5: The flag (address 1, bit 0) sets when the 16-bit count wraps from 0xFFFF to 0x0000. In separate mode it also sets when the high count wraps from 0xFF to 0x00.
- R6: With control bit 4 set, the high count holds at 0xFF instead of wrapping. In cascade mode this means the 16-bit count holds at 0xFFFF. An active edge that arrives while the count is pinned there sets the flag.
- R7: With control bit 5 clear, writing 1 to address 1 bit 0 clears the flag, and writing 0 leaves it unchanged.
- R8: With control bit 5 set, writing 1 to address 1 does not clear the flag. A read or a write of address 2 or address 3 clears it.
- R9: irq_o is high exactly when the flag is set and control bit 1 is set.
- R10: A write to a count register loads the written value. If a counted edge falls in the same cycle, the write wins: that edge adds nothing and sets no flag.
- R11: When a flag-setting overflow and a flag clear fall in the same cycle, the flag ends up set.
- R12: rdata_o returns control bits 6..0 at address 0 (bit 7 reads 0), the flag in bit 0 at address 1, the high count at address 2 and the low count at address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin0_i | input | 1 | Edge input for the low accumulator and for the 16-bit count |
| pin1_i | input | 1 | Edge input for the high accumulator in separate mode |
| timer_en_i | input | 1 | General timer enable, gates the separate 8-bit counts |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, used by fast clear |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two collisions can fall in the same clock cycle, and each is provoked on purpose. In the first, an overflow-producing edge on pin 0 meets a write of one to the flag register. The pin is raised exactly two cycles before the write strobe, so the synchronised edge pulse lands on the same rising edge as the write. The flag must read 1 afterwards. In the second, the same timing is used to place a count-register write on the cycle where an edge is counted. The count must read back the written value, not that value plus one.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd3;

  typedef struct packed {
    logic edge_fall;  // bit 6
    logic fast_clr;   // bit 5
    logic max_mode;   // bit 4
    logic en_hi;      // bit 3
    logic en_lo;      // bit 2
    logic ovf_ie;     // bit 1
    logic casc_en;    // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pacc_edge_det.sv
`timescale 1ns/1ps
module pacc_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign pulse_o = fall_i ? (prev_q & ~cur) : (~prev_q & cur);

  // one pulse per transition: never two cycles in a row (R2)
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/pacc_count.sv
`timescale 1ns/1ps
module pacc_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             casc_en_i,
  input  logic             en_lo_i,
  input  logic             en_hi_i,
  input  logic             max_mode_i,
  input  logic             timer_en_i,
  input  logic             pulse_lo_i,
  input  logic             pulse_hi_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] lo_q, hi_q;
  logic inc_lo, inc_hi, carry_out, sat, wr_any;

  always_comb begin
    wr_any = wr_lo_i | wr_hi_i;
    if (casc_en_i) begin
      inc_lo = pulse_lo_i;
      inc_hi = pulse_lo_i && (lo_q == CNT_MAX);
    end else begin
      inc_lo = pulse_lo_i && en_lo_i && timer_en_i;
      inc_hi = pulse_hi_i && en_hi_i && timer_en_i;
    end
    carry_out = inc_hi && (hi_q == CNT_MAX);
    sat       = carry_out && max_mode_i;
    ovf_o     = carry_out && !wr_any;  // a bus write cancels the edge
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_any) begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i;
    end else begin
      if (inc_lo && !(sat && casc_en_i)) lo_q <= lo_q + 1'b1;
      if (inc_hi && !sat)                hi_q <= hi_q + 1'b1;
    end
  end

  assign cnt_lo_o = lo_q;
  assign cnt_hi_o = hi_q;

  assert_write_wins_lo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i));

  assert_write_wins_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> hi_q == $past(wdata_i));

  assert_casc_free_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_en_i && pulse_lo_i && !wr_any && lo_q != CNT_MAX)
      |=> lo_q == CNT_W'($past(lo_q) + 1'b1));

  assert_sat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_mode_i && hi_q == CNT_MAX && !wr_hi_i) |=> hi_q == CNT_MAX);

  assert_gated_separate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_en_i && !timer_en_i && !wr_any) |=> lo_q == $past(lo_q) && hi_q == $past(hi_q));
endmodule

// File: rtl/pacc_regs.sv
`timescale 1ns/1ps
module pacc_regs
  import pacc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ovf_evt_i,
  input  logic [DATA_W-1:0] cnt_hi_i,
  input  logic [DATA_W-1:0] cnt_lo_i,
  output logic              casc_en_o,
  output logic              en_lo_o,
  output logic              en_hi_o,
  output logic              max_mode_o,
  output logic              edge_fall_o,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t ctrl_q;
  logic  flag_q;
  logic  ctrl_wr, flag_w1c, cnt_acc, flag_clr;

  always_comb begin
    ctrl_wr  = wr_en_i && (addr_i == A_CTRL);
    flag_w1c = wr_en_i && (addr_i == A_FLAG) && ctrl_wdata_i[0];
    cnt_acc  = (wr_en_i || rd_en_i) && (addr_i == A_CNT_HI || addr_i == A_CNT_LO);
    flag_clr = ctrl_q.fast_clr ? cnt_acc : flag_w1c;
  end

  assign wr_hi_o = wr_en_i && (addr_i == A_CNT_HI);
  assign wr_lo_o = wr_en_i && (addr_i == A_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata_i);
      if (ovf_evt_i)     flag_q <= 1'b1;  // set beats clear
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = DATA_W'(ctrl_q);
      A_FLAG:   rdata_o = DATA_W'(flag_q);
      A_CNT_HI: rdata_o = cnt_hi_i;
      default:  rdata_o = cnt_lo_i;
    endcase
  end

  assign casc_en_o   = ctrl_q.casc_en;
  assign en_lo_o     = ctrl_q.en_lo;
  assign en_hi_o     = ctrl_q.en_hi;
  assign max_mode_o  = ctrl_q.max_mode;
  assign edge_fall_o = ctrl_q.edge_fall;
  assign irq_o       = flag_q & ctrl_q.ovf_ie;

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> flag_q);

  assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.fast_clr && flag_w1c && !ovf_evt_i) |=> !flag_q);

  assert_fast_blocks_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.fast_clr && flag_w1c && !ovf_evt_i) |=> flag_q == $past(flag_q));

  assert_fast_access_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.fast_clr && cnt_acc && !ovf_evt_i) |=> !flag_q);

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.ovf_ie |-> !irq_o);
endmodule

// File: rtl/pulse_acc_pair.sv
`timescale 1ns/1ps
module pulse_acc_pair
  import pacc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin0_i,
  input  logic              pin1_i,
  input  logic              timer_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned NUM_CH = 2;

  logic [NUM_CH-1:0] pins, pulses;
  logic casc_en, en_lo, en_hi, max_mode, edge_fall;
  logic wr_hi, wr_lo, ovf_evt;
  logic [DATA_W-1:0] cnt_hi, cnt_lo;

  assign pins = {pin1_i, pin0_i};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
    pacc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pins[g]),
      .fall_i  (edge_fall),
      .pulse_o (pulses[g])
    );
  end

  pacc_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .ctrl_wdata_i (wdata_i[CTRL_W-1:0]),
    .ovf_evt_i    (ovf_evt),
    .cnt_hi_i     (cnt_hi),
    .cnt_lo_i     (cnt_lo),
    .casc_en_o    (casc_en),
    .en_lo_o      (en_lo),
    .en_hi_o      (en_hi),
    .max_mode_o   (max_mode),
    .edge_fall_o  (edge_fall),
    .wr_hi_o      (wr_hi),
    .wr_lo_o      (wr_lo),
    .rdata_o      (rdata_o),
    .irq_o        (irq_o)
  );

  pacc_count #(.CNT_W(DATA_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .casc_en_i  (casc_en),
    .en_lo_i    (en_lo),
    .en_hi_i    (en_hi),
    .max_mode_i (max_mode),
    .timer_en_i (timer_en_i),
    .pulse_lo_i (pulses[0]),
    .pulse_hi_i (pulses[1]),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .wdata_i    (wdata_i),
    .cnt_lo_o   (cnt_lo),
    .cnt_hi_o   (cnt_hi),
    .ovf_o      (ovf_evt)
  );

  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !(wr_en_i && addr_i == A_CTRL) || $past(ovf_evt) || $past(wr_en_i));
endmodule

// File: tb/pulse_acc_pair_test.sv
`timescale 1ns/1ps
module pulse_acc_pair_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin0 = 1'b0, pin1 = 1'b0, timer_en = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_acc_pair uut (
    .clk_i(clk), .rst_ni(rst_n), .pin0_i(pin0), .pin1_i(pin1),
    .timer_en_i(timer_en), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // op[31:28] addr[27:24] data[23:16] exp[15:8] req[7:0]
  // ops: 0 write, 1 read-check, 2 pulse pin0 x data, 3 pulse pin1 x data,
  //      4 timer_en=data, 5 irq-check
  localparam int N = 70;
  localparam logic [31:0] VEC [N] = '{
    32'h4_0_01_00_00, 32'h0_0_0C_00_03, 32'h2_0_03_00_00,
    32'h1_3_00_03_03, // R3 low counts pin0
    32'h3_0_02_00_00,
    32'h1_2_00_02_03, // R3 high counts pin1
    32'h4_0_00_00_00, 32'h2_0_02_00_00,
    32'h1_3_00_03_03, // R3 timer off holds
    32'h4_0_01_00_00, 32'h0_3_FE_00_0A,
    32'h1_3_00_FE_0A, // R10 load
    32'h2_0_03_00_00,
    32'h1_3_00_01_03, // R3 low wraps
    32'h1_1_00_00_03, // R3 no flag from low wrap
    32'h0_2_FF_00_05, 32'h3_0_01_00_00,
    32'h1_2_00_00_05, // R5 high wraps
    32'h1_1_00_01_05, // R5 flag set
    32'h0_1_00_00_07,
    32'h1_1_00_01_07, // R7 write 0 keeps flag
    32'h0_1_01_00_07,
    32'h1_1_00_00_07, // R7 write 1 clears
    32'h0_0_01_00_04, 32'h4_0_00_00_00, 32'h0_2_00_00_04, 32'h0_3_FE_00_04,
    32'h2_0_03_00_00,
    32'h1_2_00_01_04, // R4 carry into upper byte
    32'h1_3_00_01_04, // R4 lower byte
    32'h3_0_02_00_00,
    32'h1_3_00_01_04, // R4 pin1 ignored
    32'h1_2_00_01_04, // R4 pin1 ignored
    32'h0_2_FF_00_05, 32'h0_3_FF_00_05, 32'h2_0_01_00_00,
    32'h1_2_00_00_05, // R5 16-bit wrap
    32'h1_3_00_00_05,
    32'h1_1_00_01_05,
    32'h0_0_03_00_09,
    32'h5_0_00_01_09, // R9 irq on
    32'h0_0_01_00_09,
    32'h5_0_00_00_09, // R9 irq masked
    32'h0_1_01_00_06, 32'h0_0_11_00_06, 32'h0_2_FF_00_06, 32'h0_3_FE_00_06,
    32'h2_0_01_00_00,
    32'h1_1_00_00_06, // R6 no flag yet at FFFF
    32'h2_0_01_00_00,
    32'h1_2_00_FF_06, // R6 held
    32'h1_3_00_FF_06,
    32'h1_1_00_01_06, // R6 flag from pinned edge
    32'h0_0_18_00_06, 32'h4_0_01_00_00, 32'h0_1_01_00_06, 32'h0_2_FF_00_06,
    32'h3_0_01_00_00,
    32'h1_2_00_FF_06, // R6 separate high held
    32'h1_1_00_01_06,
    32'h0_0_20_00_08, 32'h0_1_01_00_08,
    32'h1_1_00_01_08, // R8 w1c blocked
    32'h1_2_00_FF_08, // R8 read access
    32'h1_1_00_00_08, // R8 cleared by access
    32'h0_0_4C_00_02, 32'h0_3_00_00_02, 32'h2_0_02_00_00,
    32'h1_3_00_02_02, // R2 falling edges
    32'h1_0_00_4C_0C  // R12 control readback
  };

  task automatic chk(input logic [7:0] got, input logic [7:0] exp,
                     input int req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_chk(input logic [1:0] a, input logic [7:0] e,
                         input int req, input string what);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 chk(rdata, e, req, what);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch == 0) pin0 = 1'b1; else pin1 = 1'b1;
      repeat (4) @(negedge clk);
      if (ch == 0) pin0 = 1'b0; else pin1 = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_chk(2'd0, 8'h00, 1, "reset ctrl");
    reg_chk(2'd1, 8'h00, 1, "reset flag");
    reg_chk(2'd2, 8'h00, 1, "reset hi");
    reg_chk(2'd3, 8'h00, 1, "reset lo");
    @(negedge clk); #1 chk({7'd0, irq}, 8'h00, 1, "reset irq");

    for (int s = 0; s < N; s++) begin
      logic [3:0] op, a4;
      logic [7:0] d, e, r;
      {op, a4, d, e, r} = VEC[s];
      case (op)
        4'd0: reg_wr(a4[1:0], d);
        4'd1: reg_chk(a4[1:0], e, int'(r), $sformatf("step %0d", s));
        4'd2: pulse(0, int'(d));
        4'd3: pulse(1, int'(d));
        4'd4: begin @(negedge clk); timer_en = d[0]; end
        default: begin @(negedge clk); #1 chk({7'd0, irq}, e, int'(r), $sformatf("step %0d irq", s)); end
      endcase
    end

    // R10: count write on the same cycle as a counted edge
    reg_wr(2'd0, 8'h0C);
    reg_wr(2'd3, 8'h10);
    @(negedge clk); pin0 = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wdata = 8'h40;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    pin0 = 1'b0;
    repeat (4) @(negedge clk);
    reg_chk(2'd3, 8'h40, 10, "write beats edge");

    // R11: overflow and write-one-clear on the same cycle
    reg_wr(2'd0, 8'h01);
    reg_wr(2'd2, 8'hFF);
    reg_wr(2'd3, 8'hFF);
    reg_chk(2'd1, 8'h00, 11, "flag clear before");
    @(negedge clk); pin0 = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    pin0 = 1'b0;
    repeat (4) @(negedge clk);
    reg_chk(2'd1, 8'h01, 11, "set wins over clear");
    reg_chk(2'd2, 8'h00, 11, "wrapped hi");
    reg_chk(2'd3, 8'h00, 11, "wrapped lo");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule